// File: doc/BRIEF.md
# Barrel Shift Unit with Carry and Overflow Flags

This block performs one of three 32-bit shifts in a single pass: a logical shift toward the MSB, a logical shift toward the LSB, or an arithmetic shift toward the LSB. The shift amount comes from a count input of which only the low five bits are used. The datapath is a five-level log shifter, so every amount from 0 to 31 costs the same. Each level moves the data by a fixed power of two, and the count bits choose which levels take part.

The block also computes a new carry flag and a new overflow flag from the incoming flag values. Carry is the last bit that left the operand. Overflow follows a fixed rule when the masked count is one. For any other count it holds its incoming value, which gives a fixed choice for a value that would otherwise be left open. A flag write enable tells the flag register whether to take the new values.

A valid strobe travels with the operation. The result, the flags and the enable are all registered once, so they appear one cycle after the input is accepted. A new operation can be issued on every cycle.

Top module: `shift_flags_unit`

## Requirements
- R1: Only count_i[4:0] sets the shift amount. count_i[7:5] changes nothing at the outputs, so a count of n and a count of n+32 give identical results and flags.
- R2: The op_i encoding is 2'b00 or 2'b11 for a shift toward the MSB, 2'b01 for a logical shift toward the LSB, and 2'b10 for an arithmetic shift toward the LSB. A shift toward the MSB fills the vacated low bits with zeros.
- R3: The logical shift toward the LSB (op_i=2'b01) fills the vacated high bits with zeros.
- R4: The arithmetic shift toward the LSB (op_i=2'b10) fills the vacated high bits with operand bit 31. This matches signed division by 2^n, rounded toward minus infinity.
- R5: For a shift toward the MSB with a masked count n of 1 to 31, cf_o is operand bit 32-n.
- R6: For either shift toward the LSB with a masked count n of 1 to 31, cf_o is operand bit n-1.
- R7: When the masked count is exactly 1, of_o follows the operation. For a shift toward the MSB it is result bit 31 XOR the new carry. For the arithmetic shift it is 0. For the logical shift toward the LSB it is operand bit 31.
- R8: When the masked count is 2 to 31, of_o equals of_i.
- R9: When the masked count is 0, result_o equals the operand, cf_o equals cf_i, of_o equals of_i, and flag_we_o is 0. For any nonzero masked count, flag_we_o is 1.
- R10: valid_o, result_o, cf_o, of_o and flag_we_o appear on the rising edge after the edge that accepts valid_i. valid_o is low after rst_ni is asserted (active-low, asynchronous), and it is low on the cycle after valid_i is low.
- R11: Every shift amount takes one cycle. Operations issued on consecutive cycles each produce their result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 2 | Operation select (encoding in R2) |
| operand_i | input | 32 | Value to shift |
| count_i | input | 8 | Shift count; low five bits used |
| cf_i | input | 1 | Current carry flag |
| of_i | input | 1 | Current overflow flag |
| valid_o | output | 1 | Result strobe |
| result_o | output | 32 | Shifted value |
| cf_o | output | 1 | New carry flag |
| of_o | output | 1 | New overflow flag |
| flag_we_o | output | 1 | Flag register write enable |

## Verification
All five outputs come from one register stage. Each of them is due exactly one rising edge after the edge that accepts the operation. The bench drives inputs on the falling edge. On the next falling edge it compares all outputs against a one-bit-per-step reference model computed for the operation it just issued. Because operations are issued back to back, every vector also checks that a new result arrives on every cycle. After the last operation, valid_o is checked low one cycle after valid_i falls.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    OP_LSL  = 2'b00,
    OP_LSR  = 2'b01,
    OP_ASR  = 2'b10,
    OP_LSL2 = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shift_barrel.sv
// Log shifter: right shift only; left shifts reuse it via bit reversal.
module shift_barrel #(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              to_lsb_i,
  input  logic              fill_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] lvl [SH_W+1];
  logic [DATA_W-1:0] rev_in, rev_out;

  always_comb begin
    for (int b = 0; b < DATA_W; b++) begin
      rev_in[b]  = data_i[DATA_W-1-b];
      rev_out[b] = lvl[SH_W][DATA_W-1-b];
    end
  end

  assign lvl[0] = to_lsb_i ? data_i : rev_in;

  for (genvar s = 0; s < SH_W; s++) begin : g_lvl
    localparam int Step = 1 << s;
    logic fill_s;
    assign fill_s    = to_lsb_i & fill_i;
    assign lvl[s+1]  = amt_i[s] ? {{Step{fill_s}}, lvl[s][DATA_W-1:Step]} : lvl[s];
  end

  assign data_o = to_lsb_i ? lvl[SH_W] : rev_out;
endmodule

// File: rtl/shift_flag_gen.sv
module shift_flag_gen
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SH_W-1:0]   amt_i,
  input  shift_op_e         op_i,
  input  logic              res_msb_i,
  input  logic              cf_i,
  input  logic              of_i,
  output logic              cf_o,
  output logic              of_o,
  output logic              we_o
);
  logic [SH_W:0]   left_idx;
  logic [SH_W-1:0] right_idx;
  logic            cf_new;
  logic            amt_zero, amt_one;

  assign amt_zero  = (amt_i == '0);
  assign amt_one   = (amt_i == SH_W'(1));
  assign left_idx  = (SH_W+1)'(DATA_W) - {1'b0, amt_i};
  assign right_idx = amt_i - SH_W'(1);

  always_comb begin
    unique case (op_i)
      OP_LSR, OP_ASR: cf_new = operand_i[right_idx];
      default:        cf_new = operand_i[left_idx[SH_W-1:0]];
    endcase
  end

  always_comb begin
    we_o = !amt_zero;
    cf_o = amt_zero ? cf_i : cf_new;
    of_o = of_i;
    if (amt_one) begin
      unique case (op_i)
        OP_ASR:  of_o = 1'b0;
        OP_LSR:  of_o = operand_i[DATA_W-1];
        default: of_o = res_msb_i ^ cf_new;
      endcase
    end
  end
endmodule

// File: rtl/shift_flags_unit.sv
module shift_flags_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              cf_i,
  input  logic              of_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              cf_o,
  output logic              of_o,
  output logic              flag_we_o
);
  localparam int SH_W = $clog2(DATA_W);

  shift_op_e         op;
  logic [SH_W-1:0]   amt;
  logic              to_lsb, fill;
  logic [DATA_W-1:0] shifted;
  logic              cf_d, of_d, we_d;
  logic              unused_cnt_hi;

  assign op            = shift_op_e'(op_i);
  assign amt           = count_i[SH_W-1:0];  // architectural 5-bit mask
  assign unused_cnt_hi = ^count_i[CNT_W-1:SH_W];
  assign to_lsb        = (op == OP_LSR) || (op == OP_ASR);
  assign fill          = (op == OP_ASR) & operand_i[DATA_W-1];

  shift_barrel #(.DATA_W(DATA_W), .SH_W(SH_W)) u_barrel (
    .data_i   (operand_i),
    .amt_i    (amt),
    .to_lsb_i (to_lsb),
    .fill_i   (fill),
    .data_o   (shifted)
  );

  shift_flag_gen #(.DATA_W(DATA_W), .SH_W(SH_W)) u_flags (
    .operand_i (operand_i),
    .amt_i     (amt),
    .op_i      (op),
    .res_msb_i (shifted[DATA_W-1]),
    .cf_i      (cf_i),
    .of_i      (of_i),
    .cf_o      (cf_d),
    .of_o      (of_d),
    .we_o      (we_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      cf_o      <= 1'b0;
      of_o      <= 1'b0;
      flag_we_o <= 1'b0;
    end else if (valid_i) begin
      result_o  <= shifted;
      cf_o      <= cf_d;
      of_o      <= of_d;
      flag_we_o <= we_d;
    end
  end
endmodule

// File: rtl/shift_flags_unit_chk.sv
module shift_flags_unit_chk #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] operand_i,
  input logic [CNT_W-1:0]  count_i,
  input logic              cf_i,
  input logic              of_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o,
  input logic              cf_o,
  input logic              of_o,
  input logic              flag_we_o
);
  localparam int SH_W = $clog2(DATA_W);
  logic [SH_W-1:0] amt;
  logic            v_q;
  assign amt = count_i[SH_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) v_q <= 1'b0;
    else         v_q <= valid_i;
  end

  assert_valid_latency_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == v_q);

  assert_lsl_result_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (op_i == 2'b00 || op_i == 2'b11)) |=> result_o == $past(operand_i << amt));

  assert_lsr_result_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01) |=> result_o == $past(operand_i >> amt));

  assert_asr_result_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10) |=> result_o == $past(DATA_W'($signed(operand_i) >>> amt)));

  assert_of_asr_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b10 && amt == SH_W'(1)) |=> !of_o);

  assert_of_lsr_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'b01 && amt == SH_W'(1)) |=> of_o == $past(operand_i[DATA_W-1]));

  assert_of_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amt > SH_W'(1)) |=> of_o == $past(of_i));

  assert_zero_count_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amt == '0) |=> (!flag_we_o && result_o == $past(operand_i) && cf_o == $past(cf_i)));

  assert_flag_we_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && amt != '0) |=> flag_we_o);
endmodule

bind shift_flags_unit shift_flags_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .operand_i(operand_i), .count_i(count_i), .cf_i(cf_i), .of_i(of_i),
  .valid_o(valid_o), .result_o(result_o), .cf_o(cf_o), .of_o(of_o),
  .flag_we_o(flag_we_o)
);

// File: tb/shift_flags_unit_tb.sv
module shift_flags_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [31:0] operand_i = '0;
  logic [7:0]  count_i = '0;
  logic        cf_i = 1'b0, of_i = 1'b0;
  logic        valid_o, cf_o, of_o, flag_we_o;
  logic [31:0] result_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_flags_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i),
    .operand_i(operand_i), .count_i(count_i), .cf_i(cf_i), .of_i(of_i),
    .valid_o(valid_o), .result_o(result_o), .cf_o(cf_o), .of_o(of_o),
    .flag_we_o(flag_we_o)
  );

  // Reference: one position per step, as the requirements define it.
  function automatic logic [35:0] ref_model(input logic [1:0] op, input logic [31:0] d,
                                            input logic [7:0] cnt, input logic cfi, input logic ofi);
    int n = int'(cnt & 8'h1F);
    logic [31:0] r = d;
    logic c = cfi, o = ofi;
    for (int i = 0; i < n; i++) begin
      if (op == 2'b01)      begin c = r[0];  r = {1'b0, r[31:1]};  end
      else if (op == 2'b10) begin c = r[0];  r = {r[31], r[31:1]}; end
      else                  begin c = r[31]; r = {r[30:0], 1'b0};  end
    end
    if (n == 1) begin
      if (op == 2'b01)      o = d[31];
      else if (op == 2'b10) o = 1'b0;
      else                  o = r[31] ^ c;
    end
    return {1'b1, (n != 0), o, c, r};
  endfunction

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {v,we,of,cf,res}=%h expected %h", req, act, exp);
    end
  endtask

  // Drives at falling edge; results due one rising edge later, sampled at next falling edge (R10, R11).
  task automatic run_vec(input logic [1:0] op, input logic [31:0] d, input logic [7:0] cnt,
                         input logic cfi, input logic ofi);
    logic [35:0] exp;
    string tag;
    int n = int'(cnt & 8'h1F);
    valid_i = 1'b1; op_i = op; operand_i = d; count_i = cnt; cf_i = cfi; of_i = ofi;
    exp = ref_model(op, d, cnt, cfi, ofi);
    @(negedge clk);
    if (n == 0)                     tag = "R9";
    else if (cnt > 8'd31)           tag = "R1";
    else if (result_o !== exp[31:0]) tag = (op == 2'b01) ? "R3" : (op == 2'b10) ? "R4" : "R2";
    else if (cf_o !== exp[32])      tag = (op == 2'b01 || op == 2'b10) ? "R6" : "R5";
    else if (of_o !== exp[33])      tag = (n == 1) ? "R7" : "R8";
    else                            tag = "R11";
    check(tag, {valid_o, flag_we_o, of_o, cf_o, result_o}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] corners [4];
    corners[0] = 32'h0; corners[1] = 32'hFFFF_FFFF; corners[2] = 32'h8000_0000; corners[3] = 32'h1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", {valid_o, 35'h0}, 36'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", {valid_o, 35'h0}, 36'h0);
    for (int op = 0; op < 4; op++) begin
      for (int c = 0; c < 64; c++) begin
        for (int k = 0; k < 4; k++)
          run_vec(2'(op), corners[k], 8'(c), 1'(k), 1'(~k));
        for (int k = 0; k < 6; k++)
          run_vec(2'(op), $urandom, 8'(c), 1'($urandom), 1'($urandom));
      end
      // R1: counts above 63 also masked
      run_vec(2'(op), $urandom, 8'($urandom), 1'($urandom), 1'($urandom));
      run_vec(2'(op), 32'hC000_0001, 8'hE1, 1'b0, 1'b1);
    end
    // R7: directed SHL count 1 overflow cases
    run_vec(2'b00, 32'h4000_0000, 8'd1, 1'b0, 1'b0);
    run_vec(2'b00, 32'hC000_0000, 8'd1, 1'b0, 1'b1);
    valid_i = 1'b0;
    @(negedge clk);
    check("R10", {valid_o, 35'h0}, 36'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule